// File: doc/BRIEF.md
# Micro-Packet Transport Stream Reassembler

The block takes a stream of 32-bit micro-packet words in which up to four sources are interleaved. Each word carries a source tag, a 3-bit sequence number, a packet-start flag, an overflow flag and a 3-byte payload slice. The block keeps a slice position and a continuity counter for every source. It rebuilds whole 188-byte transport packets, 63 slices to the packet, where the final slice gives only two bytes. It sends them out as a byte stream that carries the source index, a first-byte marker and a last-byte marker.

A source stays unsynchronised until a word with the start flag arrives. Words that arrive while the source is unsynchronised are dropped. A sequence gap raises a loss pulse, and a word that reports device overflow raises an overflow pulse. Both pulses carry the source index. The input uses a valid/ready handshake. The output has no backpressure and emits one byte per cycle, so the input is held off while a slice is being emitted.

Word layout (bit positions): [31:29] source tag (source index plus one), [28:26] sequence number, [25] packet start, [24] overflow, [23:16] first payload byte, [15:8] second, [7:0] third.

Top module: `mp_ts_reasm`

## Requirements
- R1: Tag value t in 1..4 selects source t-1. A word with tag 0, 5, 6 or 7 is consumed with no output byte and no flag.
- R2: A word with bit 25 set puts its source at slice 0, even in the middle of a packet. Its first byte leaves with out_sop_o high.
- R3: A word without bit 25 whose source sits at slice 0 (unsynchronised) is dropped. It produces no byte and no flag, and it does not update the continuity counter.
- R4: The payload bytes of a slice leave in the order bits 23:16, 15:8, 7:0.
- R5: A packet takes 63 slices. Slice 62 gives only its first two bytes, so a packet is 188 bytes, and out_eop_o marks byte 187. After that byte the source is back at slice 0.
- R6: For a kept word, loss_o pulses when its sequence field (bits 28:26) differs from the previous kept value for that source plus one, modulo 8. The step from 7 to 0 is no loss.
- R7: The first kept word of a source after reset sets its continuity counter and reports no loss.
- R8: A kept word with bit 24 set pulses ovf_o. The pulse carries the source index on flag_src_o.
- R9: Sources keep independent slice positions and counters when their words interleave.
- R10: The first byte of an accepted kept word appears in the cycle after acceptance, and bytes follow back to back. in_ready_o is low while a slice has bytes left, other than its last one.
- R11: In reset, out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Block can take a word |
| in_word_i | input | 32 | Micro-packet word |
| out_valid_o | output | 1 | Output byte valid |
| out_byte_o | output | 8 | Output byte |
| out_src_o | output | 2 | Source of the output byte |
| out_sop_o | output | 1 | First byte of a packet |
| out_eop_o | output | 1 | Byte 187 of a packet |
| ovf_o | output | 1 | Overflow pulse for a kept word |
| loss_o | output | 1 | Sequence gap pulse |
| flag_src_o | output | 2 | Source of the flag pulses |

## Verification
The bench sends a full packet and then a non-start word. A design that does not return to slice 0 after slice 62 would pass that word through, and one that miscounts the short last slice would place the end marker at the wrong byte. It sends a dropped word with a misleading sequence number ahead of a source's first start word. A design that lets dropped words update the counter, or that checks the very first word, would raise a false loss. The bench also covers a 7-to-0 sequence wrap, a restart in the middle of a packet, out-of-range tags that carry the overflow bit, and two interleaved full packets, where shared position state would corrupt both streams.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int TAG_W = 3;
  localparam int SEQ_W = 3;
  localparam int SLICE_BYTES = 3;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [SEQ_W-1:0] seq;
    logic             start;
    logic             ovf;
    logic [8*SLICE_BYTES-1:0] payload;
  } mp_word_t;
endpackage

// File: rtl/mpr_decode.sv
module mpr_decode
  import mpr_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 2
) (
  input  mp_word_t         word_i,
  output logic [SRC_W-1:0] src_o,
  output logic             src_ok_o,
  output logic             start_o,
  output logic             ovf_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [8*SLICE_BYTES-1:0] payload_o
);
  logic [TAG_W-1:0] idx;

  assign idx       = word_i.tag - TAG_W'(1);
  assign src_o     = SRC_W'(idx);
  assign src_ok_o  = (word_i.tag != '0) && (int'(word_i.tag) <= NUM_SRC);
  assign start_o   = word_i.start;
  assign ovf_o     = word_i.ovf;
  assign seq_o     = word_i.seq;
  assign payload_o = word_i.payload;
endmodule

// File: rtl/mpr_src_track.sv
module mpr_src_track #(
  parameter int SLICES = 63,
  parameter int SEQ_W  = 3,
  parameter int POS_W  = $clog2(SLICES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             start_i,
  input  logic [SEQ_W-1:0] seq_i,
  output logic             keep_o,
  output logic             loss_o,
  output logic [POS_W-1:0] pos_o
);
  logic [POS_W-1:0] pos_q, pos_eff;
  logic [SEQ_W-1:0] seq_q;
  logic             seen_q;

  assign pos_eff = start_i ? '0 : pos_q;
  assign pos_o   = pos_eff;
  assign keep_o  = hit_i && (start_i || pos_q != '0);
  assign loss_o  = keep_o && seen_q && (seq_i != seq_q + SEQ_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      seq_q  <= '0;
      seen_q <= 1'b0;
    end else if (keep_o) begin
      pos_q  <= (pos_eff == POS_W'(SLICES - 1)) ? '0 : pos_eff + POS_W'(1);
      seq_q  <= seq_i;
      seen_q <= 1'b1;
    end
  end

  assert_start_resync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && start_i |=> pos_q == POS_W'(1));
  assert_unsync_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && !start_i && pos_q == '0 |=> pos_q == '0 && $stable(seq_q));
  assert_pos_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < POS_W'(SLICES));
endmodule

// File: rtl/mpr_serializer.sv
module mpr_serializer #(
  parameter int SLICES = 63,
  parameter int POS_W  = $clog2(SLICES),
  parameter int SRC_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [23:0]      payload_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [SRC_W-1:0] src_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [7:0]       byte_o,
  output logic [SRC_W-1:0] src_o,
  output logic             sop_o,
  output logic             eop_o
);
  logic             busy_q, first_q, final_q;
  logic [23:0]      data_q;
  logic [1:0]       idx_q, last_idx_q;
  logic [SRC_W-1:0] src_q;

  assign busy_o = busy_q;
  assign last_o = busy_q && (idx_q == last_idx_q);
  assign src_o  = src_q;
  assign sop_o  = busy_q && first_q && (idx_q == 2'd0);
  assign eop_o  = last_o && final_q;

  always_comb begin
    case (idx_q)
      2'd0:    byte_o = data_q[23:16];
      2'd1:    byte_o = data_q[15:8];
      default: byte_o = data_q[7:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      first_q    <= 1'b0;
      final_q    <= 1'b0;
      data_q     <= '0;
      idx_q      <= '0;
      last_idx_q <= 2'd2;
      src_q      <= '0;
    end else if (load_i) begin
      busy_q     <= 1'b1;
      data_q     <= payload_i;
      idx_q      <= '0;
      first_q    <= (pos_i == '0);
      final_q    <= (pos_i == POS_W'(SLICES - 1));
      last_idx_q <= (pos_i == POS_W'(SLICES - 1)) ? 2'd1 : 2'd2;
      src_q      <= src_i;
    end else if (busy_q) begin
      if (last_o) busy_q <= 1'b0;
      else        idx_q  <= idx_q + 2'd1;
    end
  end

  assert_load_starts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o && idx_q == 2'd0);
endmodule

// File: rtl/mp_ts_reasm.sv
module mp_ts_reasm
  import mpr_pkg::*;
#(
  parameter  int NUM_SRC = 4,
  parameter  int SLICES  = 63,
  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [31:0]      in_word_i,
  output logic             out_valid_o,
  output logic [7:0]       out_byte_o,
  output logic [SRC_W-1:0] out_src_o,
  output logic             out_sop_o,
  output logic             out_eop_o,
  output logic             ovf_o,
  output logic             loss_o,
  output logic [SRC_W-1:0] flag_src_o
);
  localparam int POS_W = $clog2(SLICES);

  logic             accept;
  logic [SRC_W-1:0] src;
  logic             src_ok, start, ovf;
  logic [SEQ_W-1:0] seq;
  logic [23:0]      payload;
  logic             ser_busy, ser_last;

  logic [NUM_SRC-1:0] keep_v, loss_v;
  logic [POS_W-1:0]   pos_v [NUM_SRC];
  logic               keep_any, loss_any;
  logic [POS_W-1:0]   pos_sel;

  logic             ovf_q, loss_q;
  logic [SRC_W-1:0] flag_src_q;

  assign in_ready_o = !ser_busy || ser_last;
  assign accept     = in_valid_i && in_ready_o;

  mpr_decode #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_dec (
    .word_i    (mp_word_t'(in_word_i)),
    .src_o     (src),
    .src_ok_o  (src_ok),
    .start_o   (start),
    .ovf_o     (ovf),
    .seq_o     (seq),
    .payload_o (payload)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_trk
    logic hit;
    assign hit = accept && src_ok && (src == SRC_W'(g));
    mpr_src_track #(.SLICES(SLICES), .SEQ_W(SEQ_W), .POS_W(POS_W)) u_trk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hit_i   (hit),
      .start_i (start),
      .seq_i   (seq),
      .keep_o  (keep_v[g]),
      .loss_o  (loss_v[g]),
      .pos_o   (pos_v[g])
    );
  end

  assign keep_any = |keep_v;
  assign loss_any = |loss_v;

  always_comb begin
    pos_sel = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (keep_v[i]) pos_sel = pos_v[i];
  end

  mpr_serializer #(.SLICES(SLICES), .POS_W(POS_W), .SRC_W(SRC_W)) u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (keep_any),
    .payload_i (payload),
    .pos_i     (pos_sel),
    .src_i     (src),
    .busy_o    (ser_busy),
    .last_o    (ser_last),
    .byte_o    (out_byte_o),
    .src_o     (out_src_o),
    .sop_o     (out_sop_o),
    .eop_o     (out_eop_o)
  );

  assign out_valid_o = ser_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q      <= 1'b0;
      loss_q     <= 1'b0;
      flag_src_q <= '0;
    end else begin
      ovf_q  <= keep_any && ovf;
      loss_q <= loss_any;
      if (keep_any) flag_src_q <= src;
    end
  end

  assign ovf_o      = ovf_q;
  assign loss_o     = loss_q;
  assign flag_src_o = flag_src_q;

  assert_bad_tag_silent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !src_ok |=> !out_valid_o && !ovf_o && !loss_o);
  assert_emit_continues_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !in_ready_o |=> out_valid_o);
  assert_eop_releases_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eop_o |-> in_ready_o);
  assert_reset_idle_R11: assert property (@(posedge clk_i)
    !rst_ni |-> !out_valid_o && in_ready_o);
endmodule

// File: tb/tb_mp_ts_reasm.sv
module tb_mp_ts_reasm;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic [31:0] in_word_i = '0;
  logic in_ready_o, out_valid_o, out_sop_o, out_eop_o, ovf_o, loss_o;
  logic [7:0] out_byte_o;
  logic [1:0] out_src_o, flag_src_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  mp_ts_reasm dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_word_i(in_word_i), .out_valid_o(out_valid_o), .out_byte_o(out_byte_o),
    .out_src_o(out_src_o), .out_sop_o(out_sop_o), .out_eop_o(out_eop_o),
    .ovf_o(ovf_o), .loss_o(loss_o), .flag_src_o(flag_src_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int n_b = 0, n_ovf = 0, n_loss = 0, ovf_src = -1, loss_src = -1;
  logic [7:0] lg_byte [0:1023];
  logic [1:0] lg_src  [0:1023];
  bit lg_sop [0:1023];
  bit lg_eop [0:1023];
  int lg_cyc [0:1023];
  int acc_cyc;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_ni) begin
    if (out_valid_o && n_b < 1024) begin
      lg_byte[n_b] = out_byte_o; lg_src[n_b] = out_src_o;
      lg_sop[n_b] = out_sop_o;   lg_eop[n_b] = out_eop_o;
      lg_cyc[n_b] = cyc;         n_b = n_b + 1;
    end
    if (ovf_o)  begin n_ovf  = n_ovf + 1;  ovf_src  = int'(flag_src_o); end
    if (loss_o) begin n_loss = n_loss + 1; loss_src = int'(flag_src_o); end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int seq, input bit st,
                                     input bit ov, input logic [23:0] pl);
    return {3'(tag), 3'(seq), st, ov, pl};
  endfunction

  function automatic logic [23:0] pay(input int s, input int salt);
    return {8'(salt + 3*s), 8'(salt + 3*s + 1), 8'(salt + 3*s + 2)};
  endfunction

  task automatic send(input logic [31:0] w);
    bit acc;
    in_word_i = w; in_valid_i = 1'b1;
    do begin
      acc = in_ready_o;
      @(posedge clk); @(negedge clk);
    end while (!acc);
    acc_cyc = cyc;
    in_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    n_b = 0; n_ovf = 0; n_loss = 0; ovf_src = -1; loss_src = -1;
  endtask

  // checks one source's packet bytes in the log: byte j == salt + j
  task automatic chk_pkt(input int src, input int salt, input int nbytes, input string req);
    int j = 0, bad = 0, sops = 0, eops = 0, bad_at = -1;
    for (int k = 0; k < n_b; k++) begin
      if (int'(lg_src[k]) == src) begin
        if (lg_byte[k] != 8'(salt + j) && bad_at < 0) bad_at = j;
        if (lg_byte[k] != 8'(salt + j)) bad++;
        if (lg_sop[k]) sops += (j == 0) ? 1 : 100;
        if (lg_eop[k]) eops += (j == 187) ? 1 : 100;
        j++;
      end
    end
    chk(j == nbytes, {req, " byte count"}, j, nbytes);
    chk(bad == 0, {req, " payload order"}, bad_at, -1);
    chk(sops == 1, {req, " sop on byte 0"}, sops, 1);
    chk(eops == ((nbytes == 188) ? 1 : 0), {req, " eop on byte 187"}, eops, (nbytes == 188) ? 1 : 0);
  endtask

  task automatic t_reset();
    chk(in_ready_o == 1'b1, "R11 ready in reset", int'(in_ready_o), 1);
    chk(out_valid_o == 1'b0, "R11 valid in reset", int'(out_valid_o), 0);
  endtask

  task automatic t_single_packet();   // R4 R5 R7 R2
    clr();
    for (int s = 0; s < 63; s++) send(mk(1, s % 8, s == 0, 0, pay(s, 'h10)));
    idle(6);
    chk_pkt(0, 'h10, 188, "R5/R4");
    chk(n_loss == 0, "R7 no loss on first word", n_loss, 0);
    chk(n_ovf == 0, "R8 no ovf without bit", n_ovf, 0);
  endtask

  task automatic t_unsynced();        // R3 R5 R7
    clr();
    send(mk(1, 7, 0, 0, pay(0, 'h55)));   // src0 back at slice 0
    send(mk(2, 2, 0, 0, pay(0, 'h55)));   // src1 never synced
    idle(5);
    chk(n_b == 0, "R3/R5 non-start words dropped", n_b, 0);
    chk(n_loss == 0, "R3 dropped words raise no loss", n_loss, 0);
    send(mk(2, 5, 1, 0, pay(0, 'h40)));
    send(mk(2, 6, 0, 0, pay(1, 'h40)));
    idle(5);
    chk(n_b == 6, "R2 src1 bytes after start", n_b, 6);
    chk(n_b > 0 && lg_sop[0] && lg_src[0] == 2'd1, "R2 sop on src1", int'(lg_sop[0]), 1);
    chk(n_loss == 0, "R7 dropped word did not set counter", n_loss, 0);
  endtask

  task automatic t_bad_tag();          // R1
    clr();
    send(mk(0, 0, 1, 1, pay(0, 1)));
    send(mk(5, 0, 1, 1, pay(0, 1)));
    send(mk(7, 0, 1, 1, pay(0, 1)));
    idle(5);
    chk(n_b == 0, "R1 bad tags give no bytes", n_b, 0);
    chk(n_ovf + n_loss == 0, "R1 bad tags give no flags", n_ovf + n_loss, 0);
    send(mk(4, 0, 1, 0, pay(0, 'h70)));
    idle(5);
    chk(n_b == 3 && lg_src[0] == 2'd3, "R1 tag 4 maps to src 3", n_b, 3);
    chk(n_b == 3 && lg_byte[0] == 8'h70 && lg_byte[2] == 8'h72, "R4 byte order", int'(lg_byte[0]), 'h70);
  endtask

  task automatic t_loss();             // R6
    clr();
    send(mk(2, 0, 0, 0, pay(2, 'h40)));   // src1 last seq 6, 7 skipped
    idle(4);
    chk(n_loss == 1, "R6 gap flagged", n_loss, 1);
    chk(loss_src == 1, "R6 loss source", loss_src, 1);
    for (int s = 1; s <= 8; s++) send(mk(2, s % 8, 0, 0, pay(2 + s, 'h40)));
    idle(5);
    chk(n_loss == 1, "R6 wrap 7 to 0 no loss", n_loss, 1);
    chk(n_b == 27, "R6 bytes still delivered", n_b, 27);
  endtask

  task automatic t_ovf();              // R8 R3
    clr();
    send(mk(3, 0, 0, 1, pay(0, 1)));      // src2 unsynced, dropped
    idle(4);
    chk(n_ovf == 0, "R3 dropped word no ovf", n_ovf, 0);
    send(mk(3, 3, 1, 1, pay(0, 'h20)));
    idle(4);
    chk(n_ovf == 1 && ovf_src == 2, "R8 ovf flagged for src2", n_ovf * 10 + ovf_src, 12);
    chk(n_loss == 0, "R7 first src2 word no loss", n_loss, 0);
  endtask

  task automatic t_restart();          // R2
    clr();
    send(mk(3, 4, 0, 0, pay(1, 'h20)));
    send(mk(3, 5, 1, 0, pay(0, 'h90)));
    idle(5);
    chk(n_b == 6, "R2 both slices emitted", n_b, 6);
    chk(n_b == 6 && !lg_sop[0] && lg_sop[3], "R2 mid-packet restart sop", int'(lg_sop[3]), 1);
    chk(n_b == 6 && lg_byte[3] == 8'h90, "R2 restart payload", int'(lg_byte[3]), 'h90);
  endtask

  task automatic t_interleave();       // R9
    clr();
    for (int s = 0; s < 63; s++) begin
      send(mk(1, (7 + s) % 8, s == 0, 0, pay(s, 'h31)));
      send(mk(4, (1 + s) % 8, s == 0, 0, pay(s, 'hC7)));
    end
    idle(6);
    chk(n_b == 376, "R9 total bytes", n_b, 376);
    chk_pkt(0, 'h31, 188, "R9 src0");
    chk_pkt(3, 'hC7, 188, "R9 src3");
    chk(n_loss == 0, "R9 no cross-source loss", n_loss, 0);
  endtask

  task automatic t_timing();           // R10
    int a0, a1;
    clr();
    send(mk(2, 1, 0, 0, pay(11, 0))); a0 = acc_cyc;
    send(mk(2, 2, 0, 0, pay(12, 0))); a1 = acc_cyc;
    send(mk(2, 3, 0, 0, pay(13, 0)));
    idle(5);
    chk(n_b == 9, "R10 byte count", n_b, 9);
    chk(lg_cyc[0] == a0, "R10 first byte next cycle", lg_cyc[0] - a0, 0);
    chk(lg_cyc[8] == a0 + 8, "R10 back-to-back bytes", lg_cyc[8] - a0, 8);
    chk(a1 == a0 + 3, "R10 ready after last byte", a1 - a0, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    idle(2);
    t_single_packet();
    t_unsynced();
    t_bad_tag();
    t_loss();
    t_ovf();
    t_restart();
    t_interleave();
    t_timing();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule